// File: doc/BRIEF.md
# Attenuator Control Core with Stepped DAC Code

This block is the digital side of a voltage-controlled attenuator. A host writes and reads four 10-bit configuration words through a 4-wire SPI slave port. The block keeps a 10-bit code for an external converter and decodes an operating state that tells the analog circuits what drives the attenuators. The converter, the comparator and the attenuators are outside this block.

The code register has two sources, chosen by a level input. In direct mode the code follows configuration word 0. In step mode, a rising edge on the up input adds configuration word 1 to the code, and a rising edge on the down input subtracts word 2. The code saturates at both ends, and no SPI traffic is needed between steps.

All SPI pins are sampled in the system clock domain. The frame tracker is a state machine with these states:
- FR_IDLE: select high. It moves to FR_CMD when select falls.
- FR_CMD: collects the direction bit and the two address bits. It moves to FR_DATA on the third bit.
- FR_DATA: collects ten data bits and shifts read data out. It moves to FR_FULL on the thirteenth bit.
- FR_FULL: a complete frame is held. A write commits when select rises. Another clock edge moves it to FR_OVER.
- FR_OVER: the frame is too long. It waits for select to rise.

From every state, select going high returns the tracker to FR_IDLE.

The step logic chooses one action per clock: STEP_LOAD, STEP_UP, STEP_DN or STEP_HOLD. The decoded operating states are OP_ANALOG, OP_DAC, OP_MONITOR and OP_TEST.

Top module: `atten_ctl_top`

## Requirements
- R1: A frame is 13 bits, sent MSB first and sampled on rising SCLK while CS_n is low. Bit 12 is the direction (0 = write, 1 = read), bits 11:10 are the register address and bits 9:0 are the data. A write updates the addressed register when CS_n rises.
- R2: When CS_n rises after any bit count other than 13, the frame is discarded and no register changes.
- R3: In a read frame, the addressed register's 10 bits appear on MISO MSB first. Each bit is valid before the rising SCLK of its own data position. MISO is 0 in the first three positions and in write frames. The pad enable is high exactly while CS_n is low. A read changes no register.
- R4: With step_mode = 0, dac_code equals register 0 one clock later, and step_up and step_dn have no effect.
- R5: With step_mode = 1, a rising edge on step_up adds register 1 to dac_code. A rising edge on step_dn subtracts register 2.
- R6: Stepping saturates at 1023 going up and at 0 going down. It never wraps.
- R7: If the up edge and the down edge are detected in the same clock, dac_code does not change.
- R8: Register 3 bits [1:0] select the operating state. Bit 0 is the converter-drive bit and bit 1 is the monitor bit. The decode is:
  - 00: analog only. All outputs are 0.
  - 01: converter drive. dac_enable = 1 and atten_from_dac = 1.
  - 10: analog with alarm. dac_enable = 1 and cmp_enable = 1.
  - 11: test. dac_enable = 1, atten_from_dac = 1 and dac_to_ctrl_pin = 1.
  Register 3 bits [9:2] are stored and read back but have no effect.
- R9: Reset clears all four registers and dac_code to 0, so the decoded state is analog only.
- R10: step_up and step_dn pass through a two-flop synchronizer and a rising-edge detector. A level held high for many clocks gives exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| spi_miso_en | output | 1 | Output enable for the MISO pad; the pad is high impedance when low |
| step_mode | input | 1 | 0 = direct load from register 0, 1 = step mode |
| step_up | input | 1 | Asynchronous step-up request |
| step_dn | input | 1 | Asynchronous step-down request |
| dac_code | output | 10 | Code for the external converter |
| dac_enable | output | 1 | Converter powered |
| atten_from_dac | output | 1 | Attenuators driven by the converter rather than the control pin |
| cmp_enable | output | 1 | Converter-versus-control-pin compare alarm enabled |
| dac_to_ctrl_pin | output | 1 | Converter output routed to the control pin |

## Verification
The stepping path is tested with single up pulses and single down pulses. It is also tested with a level held high for many clocks, which separates edge detection from level sensing. Up and down pulses raised together show that simultaneous requests cancel. Steps are driven into both limits to show that the code clamps instead of wrapping. Frames of 12, 13 and 14 bits distinguish exact-length commit from a plain bit counter. Readback of register 3 with all bits set shows that the upper bits are stored while the decode uses only the low two.

// File: rtl/atten_ctl_pkg.sv
package atten_ctl_pkg;

    localparam int CODE_W   = 10;
    localparam int ADDR_W   = 2;
    localparam int FRAME_W  = 1 + ADDR_W + CODE_W;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CMD,
        FR_DATA,
        FR_FULL,
        FR_OVER
    } frame_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_LOAD,
        STEP_UP,
        STEP_DN
    } step_act_e;

    // encoding {monitor bit, converter-drive bit}
    typedef enum logic [1:0] {
        OP_ANALOG  = 2'b00,
        OP_DAC     = 2'b01,
        OP_MONITOR = 2'b10,
        OP_TEST    = 2'b11
    } op_state_e;

endpackage

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm #(
    parameter int CODE_W  = atten_ctl_pkg::CODE_W,
    parameter int ADDR_W  = atten_ctl_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [CODE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CODE_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_en
);
    import atten_ctl_pkg::*;

    localparam int FR_W   = 1 + ADDR_W + CODE_W;
    localparam int HDR_W  = 1 + ADDR_W;
    localparam int CNT_W  = $clog2(FR_W + 2);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FR_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FR_W);

    logic [2:0]      sclk_s;
    logic [1:0]      cs_s;
    logic [1:0]      mosi_s;
    logic            sclk_rise;
    logic            cs_high;

    frame_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [FR_W-1:0] shreg_q;
    logic [CODE_W-1:0] hold_q;
    logic            hold_vld_q;
    logic            is_read_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign cs_high   = cs_s[1];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: if (!cs_high) state_d = FR_CMD;
            FR_CMD: begin
                if (cs_high)                              state_d = FR_IDLE;
                else if (sclk_rise && cnt_q == LAST_HDR)  state_d = FR_DATA;
            end
            FR_DATA: begin
                if (cs_high)                              state_d = FR_IDLE;
                else if (sclk_rise && cnt_q == LAST_BIT)  state_d = FR_FULL;
            end
            FR_FULL: begin
                if (cs_high)        state_d = FR_IDLE;
                else if (sclk_rise) state_d = FR_OVER;
            end
            FR_OVER: if (cs_high) state_d = FR_IDLE;
            default: state_d = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shreg_q    <= '0;
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            is_read_q  <= 1'b0;
            wr_stb     <= 1'b0;
        end else begin
            wr_stb <= (state_q == FR_FULL) && cs_high && !shreg_q[FR_W-1];
            if (state_q == FR_IDLE || cs_high) begin
                cnt_q      <= '0;
                hold_vld_q <= 1'b0;
                is_read_q  <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    shreg_q <= {shreg_q[FR_W-2:0], mosi_s[1]};
                    if (cnt_q != FULL_CNT + 1'b1) cnt_q <= cnt_q + 1'b1;
                end
                if (state_q == FR_DATA && !hold_vld_q) begin
                    hold_q     <= rd_data;
                    hold_vld_q <= 1'b1;
                    is_read_q  <= shreg_q[HDR_W-1];
                end else if (state_q == FR_DATA && sclk_rise) begin
                    hold_q <= {hold_q[CODE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr = shreg_q[ADDR_W-1:0];
    assign wr_addr = shreg_q[FR_W-2 -: ADDR_W];
    assign wr_data = shreg_q[CODE_W-1:0];
    assign miso    = (state_q == FR_DATA) && hold_vld_q && is_read_q && hold_q[CODE_W-1];
    assign miso_en = !cs_n;

    // R1
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R2
    wr_exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cnt_q) == FULL_CNT);

    // R3
    miso_quiet_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_CMD) |-> !miso);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int CODE_W   = atten_ctl_pkg::CODE_W,
    parameter int ADDR_W   = atten_ctl_pkg::ADDR_W,
    parameter int NUM_REGS = 1 << ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CODE_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][CODE_W-1:0]  regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_stb && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
    end

    // R1
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/step_unit.sv
module step_unit #(
    parameter int CODE_W = atten_ctl_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              up_in,
    input  logic              dn_in,
    input  logic [CODE_W-1:0] direct_code,
    input  logic [CODE_W-1:0] up_amt,
    input  logic [CODE_W-1:0] dn_amt,
    output logic [CODE_W-1:0] dac_q
);
    import atten_ctl_pkg::*;

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [2:0]        up_sync, dn_sync;
    logic              up_edge, dn_edge;
    step_act_e         act_d;
    logic [CODE_W:0]   sum_w;
    logic [CODE_W-1:0] code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_sync <= '0;
            dn_sync <= '0;
        end else begin
            up_sync <= {up_sync[1:0], up_in};
            dn_sync <= {dn_sync[1:0], dn_in};
        end
    end

    assign up_edge = up_sync[1] & ~up_sync[2];
    assign dn_edge = dn_sync[1] & ~dn_sync[2];

    always_comb begin
        if (!mode)                    act_d = STEP_LOAD;
        else if (up_edge && !dn_edge) act_d = STEP_UP;
        else if (dn_edge && !up_edge) act_d = STEP_DN;
        else                          act_d = STEP_HOLD;
    end

    assign sum_w = {1'b0, dac_q} + {1'b0, up_amt};

    always_comb begin
        unique case (act_d)
            STEP_LOAD: code_d = direct_code;
            STEP_UP:   code_d = sum_w[CODE_W] ? CODE_MAX : sum_w[CODE_W-1:0];
            STEP_DN:   code_d = (dn_amt > dac_q) ? '0 : dac_q - dn_amt;
            default:   code_d = dac_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= code_d;
    end

    // R4
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> dac_q == $past(direct_code));

    // R6
    up_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && up_edge && !dn_edge) |=> dac_q >= $past(dac_q));

    // R6
    dn_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && dn_edge && !up_edge) |=> dac_q <= $past(dac_q));

    // R7
    both_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && up_edge && dn_edge) |=> $stable(dac_q));

    // R10
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_edge |=> !up_edge);

endmodule

// File: rtl/op_decode.sv
module op_decode (
    input  logic [1:0] sel,
    output logic       dac_enable,
    output logic       atten_from_dac,
    output logic       cmp_enable,
    output logic       dac_to_ctrl_pin
);
    import atten_ctl_pkg::*;

    op_state_e op;
    assign op = op_state_e'(sel);

    always_comb begin
        dac_enable      = 1'b0;
        atten_from_dac  = 1'b0;
        cmp_enable      = 1'b0;
        dac_to_ctrl_pin = 1'b0;
        unique case (op)
            OP_ANALOG: ;
            OP_DAC: begin
                dac_enable     = 1'b1;
                atten_from_dac = 1'b1;
            end
            OP_MONITOR: begin
                dac_enable = 1'b1;
                cmp_enable = 1'b1;
            end
            OP_TEST: begin
                dac_enable      = 1'b1;
                atten_from_dac  = 1'b1;
                dac_to_ctrl_pin = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/atten_ctl_top.sv
module atten_ctl_top #(
    parameter int CODE_W = atten_ctl_pkg::CODE_W,
    parameter int ADDR_W = atten_ctl_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    input  logic              step_mode,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_enable,
    output logic              atten_from_dac,
    output logic              cmp_enable,
    output logic              dac_to_ctrl_pin
);
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int REG_DIRECT = 0;
    localparam int REG_UP     = 1;
    localparam int REG_DN     = 2;
    localparam int REG_OP     = 3;

    logic                            wr_stb;
    logic [ADDR_W-1:0]               wr_addr;
    logic [CODE_W-1:0]               wr_data;
    logic [ADDR_W-1:0]               rd_addr;
    logic [NUM_REGS-1:0][CODE_W-1:0] regs;

    spi_frame_fsm #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (spi_cs_n),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rd_data (regs[rd_addr]),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .miso    (spi_miso),
        .miso_en (spi_miso_en)
    );

    cfg_regfile #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    step_unit #(.CODE_W(CODE_W)) u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (step_mode),
        .up_in       (step_up),
        .dn_in       (step_dn),
        .direct_code (regs[REG_DIRECT]),
        .up_amt      (regs[REG_UP]),
        .dn_amt      (regs[REG_DN]),
        .dac_q       (dac_code)
    );

    op_decode u_dec (
        .sel             (regs[REG_OP][1:0]),
        .dac_enable      (dac_enable),
        .atten_from_dac  (atten_from_dac),
        .cmp_enable      (cmp_enable),
        .dac_to_ctrl_pin (dac_to_ctrl_pin)
    );

    // R8
    alarm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_enable && atten_from_dac));

    // R8
    enable_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_enable || atten_from_dac || dac_to_ctrl_pin) |-> dac_enable);

endmodule

// File: tb/atten_ctl_top_tb.sv
`timescale 1ns/1ps
module atten_ctl_top_tb;

    localparam int K_DAC = 0;
    localparam int K_RD  = 1;
    localparam int K_OP  = 2;
    localparam int K_OE  = 3;

    typedef struct {
        string      req;
        int         kind;
        logic [9:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_en;
    logic       step_mode = 1'b0;
    logic       step_up = 1'b0;
    logic       step_dn = 1'b0;
    logic [9:0] dac_code;
    logic       dac_enable, atten_from_dac, cmp_enable, dac_to_ctrl_pin;

    item_t      q[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic [9:0] rd_last = '0;
    logic [9:0] mdl_reg [4];
    logic [9:0] mdl_dac = '0;

    always #10 clk = ~clk;

    atten_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
        .step_mode(step_mode), .step_up(step_up), .step_dn(step_dn),
        .dac_code(dac_code), .dac_enable(dac_enable),
        .atten_from_dac(atten_from_dac), .cmp_enable(cmp_enable),
        .dac_to_ctrl_pin(dac_to_ctrl_pin)
    );

    // monitor: pops one expected item per falling edge and compares it
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it = q.pop_front();
            case (it.kind)
                K_DAC:   act = dac_code;
                K_RD:    act = rd_last;
                K_OP:    act = {6'd0, dac_enable, atten_from_dac, cmp_enable, dac_to_ctrl_pin};
                default: act = {9'd0, spi_miso_en};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input string req, input int kind, input logic [9:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic spi_frame(input int nbits, input logic [12:0] frame, input bit chk_oe);
        logic [9:0] rd;
        rd = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        if (chk_oe) push("R3", K_OE, 10'd1);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 13) ? frame[12-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i >= 3 && i < 13) rd[12-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        rd_last = rd;
    endtask

    task automatic wr(input int a, input logic [9:0] d);
        spi_frame(13, {1'b0, 2'(a), d}, 1'b0);
        mdl_reg[a] = d;
        if (!step_mode && a == 0) mdl_dac = d;
    endtask

    task automatic rd_chk(input string req, input int a);
        spi_frame(13, {1'b1, 2'(a), 10'd0}, 1'b0);
        push(req, K_RD, mdl_reg[a]);
    endtask

    task automatic pulse(input bit up, input bit dn, input int hold);
        step_up = up;
        step_dn = dn;
        repeat (hold) @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [9:0] sat_up(input logic [9:0] c, input logic [9:0] s);
        int v;
        v = int'(c) + int'(s);
        return (v > 1023) ? 10'd1023 : 10'(v);
    endfunction

    function automatic logic [9:0] sat_dn(input logic [9:0] c, input logic [9:0] s);
        return (s > c) ? 10'd0 : c - s;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset state
        push("R9", K_DAC, 10'd0);
        push("R9", K_OP, 10'b0000);
        push("R9", K_OE, 10'd0);
        rd_chk("R9", 2);

        // R1 R4 direct load, R3 readback and pad enable
        wr(0, 10'h155);
        push("R4", K_DAC, mdl_dac);
        spi_frame(13, {1'b1, 2'd0, 10'd0}, 1'b1);
        push("R3", K_RD, 10'h155);
        push("R3", K_OE, 10'd0);
        wr(1, 10'd100);
        wr(2, 10'd40);
        rd_chk("R1", 1);
        rd_chk("R1", 2);

        // R8 decode, upper bits stored but inert
        wr(3, 10'h3FD);
        push("R8", K_OP, 10'b1100);
        rd_chk("R8", 3);
        wr(3, 10'h002);
        push("R8", K_OP, 10'b1010);
        wr(3, 10'h003);
        push("R8", K_OP, 10'b1101);
        wr(3, 10'h000);
        push("R8", K_OP, 10'b0000);

        // R4 pulses ignored in direct mode
        pulse(1, 0, 2);
        pulse(0, 1, 2);
        push("R4", K_DAC, 10'h155);

        // R5 stepping
        step_mode = 1'b1;
        repeat (3) @(negedge clk);
        pulse(1, 0, 2);
        mdl_dac = sat_up(mdl_dac, mdl_reg[1]);
        push("R5", K_DAC, mdl_dac);
        pulse(0, 1, 2);
        mdl_dac = sat_dn(mdl_dac, mdl_reg[2]);
        push("R5", K_DAC, mdl_dac);

        // R10 held level gives one step
        pulse(1, 0, 40);
        mdl_dac = sat_up(mdl_dac, mdl_reg[1]);
        push("R10", K_DAC, mdl_dac);

        // R7 simultaneous
        pulse(1, 1, 3);
        push("R7", K_DAC, mdl_dac);

        // R6 saturation both ends
        wr(1, 10'd1000);
        pulse(1, 0, 2);
        mdl_dac = sat_up(mdl_dac, mdl_reg[1]);
        push("R6", K_DAC, 10'd1023);
        pulse(1, 0, 2);
        push("R6", K_DAC, 10'd1023);
        wr(2, 10'd1000);
        pulse(0, 1, 2);
        mdl_dac = sat_dn(mdl_dac, mdl_reg[2]);
        push("R6", K_DAC, mdl_dac);
        pulse(0, 1, 2);
        mdl_dac = sat_dn(mdl_dac, mdl_reg[2]);
        push("R6", K_DAC, 10'd0);

        // R2 wrong lengths discarded
        spi_frame(12, {1'b0, 2'd1, 10'h2AA}, 1'b0);
        rd_chk("R2", 1);
        spi_frame(14, {1'b0, 2'd1, 10'h2AA}, 1'b0);
        rd_chk("R2", 1);
        spi_frame(14, {1'b0, 2'd3, 10'h003}, 1'b0);
        push("R2", K_OP, 10'b0000);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule